// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block turns the 16-bit address of an 8-bit microcontroller bus into one-hot chip selects. It serves eight primary flash sectors, four secondary flash sectors, one SRAM, one I/O register window and one peripheral window. Each region is a parameterized inclusive address range. The selects are combinational in the address, the strobes and the mapping register, so they follow the bus within the same cycle.

Ranges may overlap across classes. A fixed three-tier priority picks the winner. SRAM, I/O and peripheral ranges sit in the top tier, secondary flash in the middle tier and primary flash in the bottom tier. A register written through the bus decides which strobe each memory class answers: the program-fetch strobe, the data-read strobe, or both. This lets software move memories between the code space and the data space while the system runs.

Default ranges:

| Region | Range |
|---|---|
| Primary 0 | 8000h–BFFFh |
| Primary 1 | C000h–FFFFh |
| Primary 2 | 0000h–1FFFh |
| Primary 3 | 2000h–3FFFh |
| Primary 4 | 4000h–4FFFh |
| Primary 5 | 5000h–5FFFh |
| Primary 6 | 6000h–6FFFh |
| Primary 7 | 7000h–7FFFh |
| Secondary 0 | 8000h–9FFFh |
| Secondary 1 | E000h–EFFFh |
| Secondary 2 | 2000h–27FFh |
| Secondary 3 | F000h–F7FFh |
| SRAM | 8000h–87FFh |
| I/O window | 7F00h–7FFFh |
| Peripheral window | 7E00h–7EFFh |

The mapping register lives at offset 00h of the I/O window, which is address 7F00h.

Top module: `cs_prio_decoder`

## Requirements
- R1: After reset the mapping register holds 0Ch (separate mode). In this mode primary flash answers only the program strobe. Secondary flash, SRAM, I/O and peripheral answer only the read strobe.
- R2: With no strobe asserted (program, read and write all low), every select output is 0.
- R3: An enabled SRAM, I/O or peripheral hit takes the access over any secondary or primary hit at the same address.
- R4: An enabled secondary flash hit takes the access over a primary flash hit at the same address.
- R5: With mapping 1Ch, a read routes as follows: 8000h–87FFh to the SRAM, 8800h–9FFFh to secondary sector 0, and A000h–BFFFh to primary sector 0.
- R6: At most one select output is high in any cycle. When no enabled region matches, all selects are 0.
- R7: On the program strobe alone, the mapping register gates each class:
  - bit 0 lets SRAM answer;
  - bit 1 lets secondary flash answer;
  - bit 2 lets primary flash answer;
  - I/O and peripheral never answer.
- R8: On the read strobe, the mapping register gates flash:
  - bit 3 lets secondary flash answer;
  - bit 4 lets primary flash answer;
  - SRAM, I/O and peripheral always answer.
- R9: When the write strobe is high, every class is enabled regardless of the mapping bits.
- R10: A write strobe at the mapping register address loads wr_data on that clock edge, and the new mapping governs the next cycle. A write to any other address leaves the mapping unchanged.
- R11: With bits 2 and 4 both set, primary flash answers both the program strobe and the read strobe.
- R12: A matching region whose class is disabled for the current strobe does not block a lower tier. For example, a program fetch at 8000h under mapping 1Ch selects primary sector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mapping register |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Bus address |
| prog_stb | input | 1 | Program-fetch strobe, active high |
| rd_stb | input | 1 | Data-read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| wr_data | input | 8 | Write data for the mapping register |
| pri_cs | output | 8 | Primary flash sector selects |
| sec_cs | output | 4 | Secondary flash sector selects |
| sram_cs | output | 1 | SRAM select |
| io_cs | output | 1 | I/O register window select |
| per_cs | output | 1 | Peripheral window select |

## Verification
Directed accesses check the priority tiers:
- They target the stacked 8000h region under several mappings.
- The program strobe at 8000h steps through SRAM, secondary and primary as the mapping bits are toggled. This separates "disabled class does not block" from "disabled class blocks".

Reads and program fetches in the I/O and peripheral windows separate the always-read rule from flash gating. Writes under an all-zero mapping show that the write strobe overrides the gating. A write just beside the register offset shows that the register decode is exact.

Random addresses, strobe mixes and mapping rewrites are then checked against a bench model of the whole select vector.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef logic [7:0] cs_map_t;

  // inclusive range test
  function automatic logic f_in_rng(input int unsigned a, input int unsigned lo,
                                    input int unsigned hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // class enables from strobes and mapping bits
  function automatic logic f_en_sram(input cs_map_t m, input logic p, input logic r,
                                     input logic w);
    return w | r | (p & m[0]);
  endfunction

  function automatic logic f_en_io(input logic r, input logic w);
    return w | r;
  endfunction

  function automatic logic f_en_sec(input cs_map_t m, input logic p, input logic r,
                                    input logic w);
    return w | (r & m[3]) | (p & m[1]);
  endfunction

  function automatic logic f_en_pri(input cs_map_t m, input logic p, input logic r,
                                    input logic w);
    return w | (r & m[4]) | (p & m[2]);
  endfunction

endpackage

// File: rtl/cs_range_bank.sv
module cs_range_bank #(
  parameter int AW = 16,
  parameter int N  = 4,
  parameter logic [N*AW-1:0] LO = '0,
  parameter logic [N*AW-1:0] HI = '0
) (
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  hit
);
  import cs_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_rng
    localparam logic [AW-1:0] RLO = LO[i*AW +: AW];
    localparam logic [AW-1:0] RHI = HI[i*AW +: AW];
    assign hit[i] = f_in_rng(int'(addr), int'(RLO), int'(RHI));
  end

endmodule

// File: rtl/cs_map_reg.sv
module cs_map_reg #(
  parameter logic [7:0] RST_VAL = 8'h0C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [7:0] wdata,
  output logic [7:0] map_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  map_q <= RST_VAL;
    else if (ld) map_q <= wdata;
  end

  AST_MAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (map_q == $past(wdata)));  // R10
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(map_q));  // R10

endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
  parameter int NP = 8,
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    l1_hit,   // bit0 SRAM, bit1 I/O, bit2 peripheral
  input  logic [NS-1:0] sec_hit,
  input  logic [NP-1:0] pri_hit,
  input  logic          en_sram,
  input  logic          en_io,
  input  logic          en_sec,
  input  logic          en_pri,
  output logic [2:0]    sel_l1,
  output logic [NS-1:0] sel_sec,
  output logic [NP-1:0] sel_pri,
  output logic          l1_any,
  output logic          sec_any
);

  logic [2:0]    l1_q;
  logic [NS-1:0] sec_q;
  logic [NP-1:0] pri_q;
  logic          pri_any;

  assign l1_q    = l1_hit & {en_io, en_io, en_sram};
  assign sec_q   = en_sec ? sec_hit : '0;
  assign pri_q   = en_pri ? pri_hit : '0;
  assign l1_any  = |l1_q;
  assign sec_any = |sec_q;
  assign pri_any = |pri_q;

  // lowest index wins inside a tier so the outputs stay one-hot
  always_comb begin
    sel_l1  = '0;
    sel_sec = '0;
    sel_pri = '0;
    if (l1_any) begin
      for (int i = 2; i >= 0; i--) if (l1_q[i]) sel_l1 = 3'(1 << i);
    end else if (sec_any) begin
      for (int i = NS - 1; i >= 0; i--) if (sec_q[i]) sel_sec = NS'(1 << i);
    end else if (pri_any) begin
      for (int i = NP - 1; i >= 0; i--) if (pri_q[i]) sel_pri = NP'(1 << i);
    end
  end

  AST_L1_OVER_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    l1_any |-> (sel_sec == '0 && sel_pri == '0));  // R3
  AST_SEC_OVER_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    sec_any |-> (sel_pri == '0));  // R4
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_l1, sel_sec, sel_pri}));  // R6

endmodule

// File: rtl/cs_prio_decoder.sv
module cs_prio_decoder #(
  parameter int AW = 16,
  parameter int NP = 8,
  parameter int NS = 4,
  parameter logic [NP*AW-1:0] PRI_LO = {16'h7000, 16'h6000, 16'h5000, 16'h4000,
                                        16'h2000, 16'h0000, 16'hC000, 16'h8000},
  parameter logic [NP*AW-1:0] PRI_HI = {16'h7FFF, 16'h6FFF, 16'h5FFF, 16'h4FFF,
                                        16'h3FFF, 16'h1FFF, 16'hFFFF, 16'hBFFF},
  parameter logic [NS*AW-1:0] SEC_LO = {16'hF000, 16'h2000, 16'hE000, 16'h8000},
  parameter logic [NS*AW-1:0] SEC_HI = {16'hF7FF, 16'h27FF, 16'hEFFF, 16'h9FFF},
  parameter logic [AW-1:0] SRAM_LO = 16'h8000,
  parameter logic [AW-1:0] SRAM_HI = 16'h87FF,
  parameter logic [AW-1:0] IO_LO   = 16'h7F00,
  parameter logic [AW-1:0] IO_HI   = 16'h7FFF,
  parameter logic [AW-1:0] PER_LO  = 16'h7E00,
  parameter logic [AW-1:0] PER_HI  = 16'h7EFF,
  parameter logic [AW-1:0] MAP_OFS = 16'h0000,
  parameter logic [7:0]    MAP_RST = 8'h0C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          prog_stb,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [7:0]    wr_data,
  output logic [NP-1:0] pri_cs,
  output logic [NS-1:0] sec_cs,
  output logic          sram_cs,
  output logic          io_cs,
  output logic          per_cs
);
  import cs_pkg::*;

  localparam logic [AW-1:0]   MAP_ADDR = IO_LO + MAP_OFS;
  localparam logic [3*AW-1:0] L1_LO    = {PER_LO, IO_LO, SRAM_LO};
  localparam logic [3*AW-1:0] L1_HI    = {PER_HI, IO_HI, SRAM_HI};

  cs_map_t       map_q;
  logic          map_ld;
  logic [2:0]    l1_hit, sel_l1;
  logic [NS-1:0] sec_hit;
  logic [NP-1:0] pri_hit;
  logic          en_sram, en_io, en_sec, en_pri;
  logic          l1_any, sec_any;

  assign map_ld = wr_stb && (bus_addr == MAP_ADDR);

  cs_map_reg #(.RST_VAL(MAP_RST)) i_map (
    .clk(clk), .rst_n(rst_n), .ld(map_ld), .wdata(wr_data), .map_q(map_q));

  cs_range_bank #(.AW(AW), .N(3), .LO(L1_LO), .HI(L1_HI)) i_l1 (
    .addr(bus_addr), .hit(l1_hit));
  cs_range_bank #(.AW(AW), .N(NS), .LO(SEC_LO), .HI(SEC_HI)) i_sec (
    .addr(bus_addr), .hit(sec_hit));
  cs_range_bank #(.AW(AW), .N(NP), .LO(PRI_LO), .HI(PRI_HI)) i_pri (
    .addr(bus_addr), .hit(pri_hit));

  assign en_sram = f_en_sram(map_q, prog_stb, rd_stb, wr_stb);
  assign en_io   = f_en_io(rd_stb, wr_stb);
  assign en_sec  = f_en_sec(map_q, prog_stb, rd_stb, wr_stb);
  assign en_pri  = f_en_pri(map_q, prog_stb, rd_stb, wr_stb);

  cs_prio_pick #(.NP(NP), .NS(NS)) i_pick (
    .clk(clk), .rst_n(rst_n),
    .l1_hit(l1_hit), .sec_hit(sec_hit), .pri_hit(pri_hit),
    .en_sram(en_sram), .en_io(en_io), .en_sec(en_sec), .en_pri(en_pri),
    .sel_l1(sel_l1), .sel_sec(sec_cs), .sel_pri(pri_cs),
    .l1_any(l1_any), .sec_any(sec_any));

  assign sram_cs = sel_l1[0];
  assign io_cs   = sel_l1[1];
  assign per_cs  = sel_l1[2];

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_stb | rd_stb | wr_stb) |-> ({pri_cs, sec_cs, sram_cs, io_cs, per_cs} == '0));  // R2
  AST_PRI_PROG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb && !rd_stb && !wr_stb && !map_q[2]) |-> (pri_cs == '0));  // R7
  AST_IO_NOT_ON_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb && !rd_stb && !wr_stb) |-> !(io_cs || per_cs));  // R7
  AST_WRITE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (|pri_hit || |sec_hit || |l1_hit))
      |-> ({pri_cs, sec_cs, sram_cs, io_cs, per_cs} != '0));  // R9

endmodule

// File: tb/test_cs_prio_decoder.sv
module test_cs_prio_decoder;

  logic        clk = 0, rst_n = 0;
  logic [15:0] bus_addr = '0;
  logic        prog_stb = 0, rd_stb = 0, wr_stb = 0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  pri_cs;
  logic [3:0]  sec_cs;
  logic        sram_cs, io_cs, per_cs;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl_map = 8'h0C;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  cs_prio_decoder i_cs_prio_decoder (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .prog_stb(prog_stb),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data), .pri_cs(pri_cs),
    .sec_cs(sec_cs), .sram_cs(sram_cs), .io_cs(io_cs), .per_cs(per_cs));

  // bench map of default ranges; result {per,io,sram,sec[3:0],pri[7:0]}
  function automatic logic [14:0] model(input logic [15:0] a, input logic p,
                                        input logic r, input logic w,
                                        input logic [7:0] m);
    logic [14:0] v = '0;
    int pi;
    int si = -1;
    bit s_ok = w || (p && m[0]) || r;
    bit x_ok = w || r;
    bit sc_ok = w || (p && m[1]) || (r && m[3]);
    bit pr_ok = w || (p && m[2]) || (r && m[4]);
    if (s_ok && a[15:11] == 5'b10000)       v[12] = 1;
    else if (x_ok && a[15:8] == 8'h7F)      v[13] = 1;
    else if (x_ok && a[15:8] == 8'h7E)      v[14] = 1;
    else begin
      if (a[15:13] == 3'b100)       si = 0;
      else if (a[15:12] == 4'hE)    si = 1;
      else if (a[15:11] == 5'b00100) si = 2;
      else if (a[15:11] == 5'b11110) si = 3;
      if (sc_ok && si >= 0) v[8+si] = 1;
      else if (pr_ok) begin
        case (a[15:12])
          4'h8, 4'h9, 4'hA, 4'hB: pi = 0;
          4'hC, 4'hD, 4'hE, 4'hF: pi = 1;
          4'h0, 4'h1: pi = 2;
          4'h2, 4'h3: pi = 3;
          default:    pi = int'(a[15:12]);  // 4..7
        endcase
        v[pi] = 1;
      end
    end
    return v;
  endfunction

  task automatic acc(input logic [15:0] a, input logic p, input logic r,
                     input logic w, input logic [7:0] d, input string req);
    logic [14:0] exp, got;
    @(negedge clk);
    bus_addr = a; prog_stb = p; rd_stb = r; wr_stb = w; wr_data = d;
    #1;
    exp = model(a, p, r, w, mdl_map);
    got = {per_cs, io_cs, sram_cs, sec_cs, pri_cs};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h p%0b r%0b w%0b got=%h exp=%h", req, a, p, r, w, got, exp);
    end
    if (w && a == 16'h7F00) mdl_map = d;  // takes effect at the coming edge
  endtask

  initial begin
    #150000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] ra;
    logic [7:0]  rd;
    int k;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    // R1 reset mapping 0Ch
    acc(16'hA000, 1, 0, 0, 0, "R1");
    acc(16'hA000, 0, 1, 0, 0, "R1");
    acc(16'h8800, 0, 1, 0, 0, "R1");
    acc(16'h8800, 1, 0, 0, 0, "R1");
    acc(16'h8000, 0, 1, 0, 0, "R3");
    // R2 no strobe
    acc(16'h8000, 0, 0, 0, 0, "R2");
    // R10 write next to the register: no change
    acc(16'h7F01, 0, 0, 1, 8'h1C, "R10");
    acc(16'hA000, 0, 1, 0, 0, "R10");
    acc(16'h7F00, 0, 0, 1, 8'h1C, "R10");
    // R5 example routing
    acc(16'h8000, 0, 1, 0, 0, "R5");
    acc(16'h87FF, 0, 1, 0, 0, "R5");
    acc(16'h8800, 0, 1, 0, 0, "R5");
    acc(16'h9FFF, 0, 1, 0, 0, "R4");
    acc(16'hA000, 0, 1, 0, 0, "R5");
    acc(16'hBFFF, 0, 1, 0, 0, "R11");
    acc(16'hA000, 1, 0, 0, 0, "R11");
    acc(16'h8000, 1, 0, 0, 0, "R12");
    acc(16'h7F00, 0, 0, 1, 8'h1E, "R10");
    acc(16'h8000, 1, 0, 0, 0, "R7");
    acc(16'h7F00, 0, 0, 1, 8'h1F, "R10");
    acc(16'h8000, 1, 0, 0, 0, "R7");
    acc(16'h7F10, 1, 0, 0, 0, "R7");
    acc(16'h7F10, 0, 1, 0, 0, "R8");
    acc(16'h7E20, 0, 1, 0, 0, "R8");
    acc(16'h7E20, 1, 0, 0, 0, "R7");
    // R9 writes open everything
    acc(16'h7F00, 0, 0, 1, 8'h00, "R10");
    acc(16'hA000, 0, 0, 1, 8'h00, "R9");
    acc(16'h8800, 0, 0, 1, 8'h00, "R9");
    acc(16'hA000, 0, 1, 0, 0, "R6");
    acc(16'h8800, 1, 0, 0, 0, "R6");
    acc(16'h8000, 1, 0, 0, 0, "R8");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      k  = $urandom_range(0, 9);
      ra = (k == 0) ? 16'h7F00 : 16'($urandom);
      rd = 8'($urandom);
      if (k < 2) acc(ra, 0, 0, 1, rd, "R6");
      else acc(ra, 1'($urandom), 1'($urandom), 1'(k == 2), rd, "R6");
    end
    @(negedge clk);
    prog_stb = 0; rd_stb = 0; wr_stb = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule